// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block keeps the replacement history for every set of an eight-way set-associative cache and names the way to evict when a line must be filled. Each set owns a seven-bit binary decision tree. A cache controller presents the set index together with that set's eight valid flags. The block answers in the same cycle with the victim way. When the controller hits or fills a way, it raises the touch strobe with the way number. On the next clock edge, the tree of the addressed set is steered away from that way.

The victim comes from one of two sources, kept in the enumerated type `pick_src_e`. `PICK_FILL` is used while any way of the set is still invalid: the lowest-numbered empty way is chosen and the tree is ignored. `PICK_TREE` is used when all eight ways are valid: the tree is walked from its root. The only stored state is the per-set tree. Its single transition is "touch": on a clock edge with the strobe high, the addressed tree moves to the fixed pattern for the touched way. Otherwise the tree holds.

Top module: `tplru8_sel`

## Requirements
- R1: While reset (`rst_n` low) is active, and after it is released, every set's tree is all zeros. With all ways valid and no touch yet, the victim of any set is way 0.
- R2: When `valid_vec` has at least one zero bit (bit i is the valid flag of way i), `victim_way` is the index of the lowest zero bit.
- R3: When `valid_vec` is 8'hFF, the victim comes from walking the set's tree. Tree bit 0 set selects ways 4–7, clear selects ways 0–3. In the upper half, bit 2 set selects ways 6–7 over 4–5, then bit 6 set selects 7 over 6, and bit 5 set selects 5 over 4. In the lower half, bit 1 set selects ways 2–3 over 0–1, then bit 4 set selects 3 over 2, and bit 3 set selects 1 over 0.
- R4: A touch writes fixed values to some tree bits and leaves the others alone. Way 0 sets bits 0, 1 and 3. Way 1 sets bits 0 and 1 and clears bit 3. Way 2 sets bits 0 and 4 and clears bit 1. Way 3 sets bit 0 and clears bits 1 and 4. Way 4 sets bits 2 and 5 and clears bit 0. Way 5 sets bit 2 and clears bits 0 and 5. Way 6 sets bit 6 and clears bits 0 and 2. Way 7 clears bits 0, 2 and 6.
- R5: A touch takes effect on the clock edge that samples `touch_en` high. `victim_way` in that same cycle still reflects the tree from before the update.
- R6: A touch changes only the tree of the set given by `set_idx` in that cycle. All other sets keep their trees.
- R7: With `touch_en` low, no tree changes, whatever `set_idx` and `valid_vec` do.
- R8: Right after way w of a set is touched, a tree walk of that set does not return w.
- R9: A touch updates the tree even when the set still has invalid ways. The update becomes visible as soon as all ways are valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the tree update happens on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all trees |
| set_idx | input | SET_W (7) | Set used for both the victim lookup and the touch |
| valid_vec | input | 8 | Valid flags of the addressed set, bit i for way i |
| touch_en | input | 1 | Access strobe; the tree of `set_idx` is updated on the next edge |
| touch_way | input | 3 | Way that was accessed, used when `touch_en` is high |
| victim_way | output | 3 | Way to replace in the addressed set (combinational) |

## Verification
`victim_way` is combinational, so it is due in the same cycle as `set_idx` and `valid_vec`. A touch shows up in the victim only in the cycle after the edge that samples the strobe. The bench drives inputs on the falling edge, then compares `victim_way` against a behavioural model a short delay later, still before the rising edge. The model tree is updated only at the rising edge. This keeps the comparison in the touch cycle on the old tree, as R5 demands, and moves it to the new tree from the next cycle on.

// File: rtl/tplru8_pkg.sv
package tplru8_pkg;

    localparam int NWAYS   = 8;
    localparam int WAY_W   = $clog2(NWAYS);
    localparam int TREE_W  = NWAYS - 1;

    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef enum logic {
        PICK_FILL = 1'b0,
        PICK_TREE = 1'b1
    } pick_src_e;

    // Apply the fixed steering pattern for an accessed way.
    function automatic tree_t tree_touch(input tree_t cur, input way_t w);
        tree_t nxt;
        nxt = cur;
        unique case (w)
            3'd0: begin nxt[0] = 1'b1; nxt[1] = 1'b1; nxt[3] = 1'b1; end
            3'd1: begin nxt[0] = 1'b1; nxt[1] = 1'b1; nxt[3] = 1'b0; end
            3'd2: begin nxt[0] = 1'b1; nxt[1] = 1'b0; nxt[4] = 1'b1; end
            3'd3: begin nxt[0] = 1'b1; nxt[1] = 1'b0; nxt[4] = 1'b0; end
            3'd4: begin nxt[0] = 1'b0; nxt[2] = 1'b1; nxt[5] = 1'b1; end
            3'd5: begin nxt[0] = 1'b0; nxt[2] = 1'b1; nxt[5] = 1'b0; end
            3'd6: begin nxt[0] = 1'b0; nxt[2] = 1'b0; nxt[6] = 1'b1; end
            default: begin nxt[0] = 1'b0; nxt[2] = 1'b0; nxt[6] = 1'b0; end
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tplru8_tree_mem.sv
module tplru8_tree_mem
    import tplru8_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             touch_en,
    input  way_t             touch_way,
    output tree_t            rd_tree
);

    tree_t tree_q [SETS];

    assign rd_tree = tree_q[set_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (touch_en) begin
            tree_q[set_idx] <= tree_touch(tree_q[set_idx], touch_way);
        end
    end

    AST_HOLD_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_en |=> (set_idx != $past(set_idx)) || (rd_tree == $past(rd_tree))); // R7

    AST_ROOT_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (set_idx != $past(set_idx)) || (rd_tree[0] == ($past(touch_way) < 3'd4))); // R4

endmodule

// File: rtl/tplru8_tree_walk.sv
module tplru8_tree_walk
    import tplru8_pkg::*;
(
    input  tree_t tree,
    output way_t  way
);

    logic upper;
    logic pair_hi;
    logic leaf_odd;

    always_comb begin
        upper = tree[0];
        if (upper) begin
            pair_hi  = tree[2];
            leaf_odd = pair_hi ? tree[6] : tree[5];
        end else begin
            pair_hi  = tree[1];
            leaf_odd = pair_hi ? tree[4] : tree[3];
        end
        way = {upper, pair_hi, leaf_odd};
    end

endmodule

// File: rtl/tplru8_empty_pick.sv
module tplru8_empty_pick
    import tplru8_pkg::*;
(
    input  logic [NWAYS-1:0] valid_vec,
    output logic             any_empty,
    output way_t             empty_way
);

    logic [NWAYS-1:0] first_hot;

    // One-hot of the lowest clear valid flag.
    generate
        for (genvar i = 0; i < NWAYS; i++) begin : g_first
            if (i == 0) begin : g_base
                assign first_hot[i] = ~valid_vec[0];
            end else begin : g_rest
                assign first_hot[i] = ~valid_vec[i] & (&valid_vec[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        empty_way = '0;
        for (int i = 0; i < NWAYS; i++) begin
            if (first_hot[i]) empty_way = way_t'(i);
        end
    end

    assign any_empty = |first_hot;

    always_comb begin
        AST_FIRST_ONEHOT: assert ($onehot0(first_hot)); // R2
    end

endmodule

// File: rtl/tplru8_sel.sv
module tplru8_sel
    import tplru8_pkg::*;
#(
    parameter int SETS  = 128,
    parameter int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic [7:0]       valid_vec,
    input  logic             touch_en,
    input  logic [2:0]       touch_way,
    output logic [2:0]       victim_way
);

    tree_t     cur_tree;
    way_t      tree_way;
    way_t      empty_way;
    logic      any_empty;
    pick_src_e src;

    tplru8_tree_mem #(.SETS(SETS), .SET_W(SET_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (set_idx),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .rd_tree   (cur_tree)
    );

    tplru8_tree_walk u_walk (
        .tree (cur_tree),
        .way  (tree_way)
    );

    tplru8_empty_pick u_empty (
        .valid_vec (valid_vec),
        .any_empty (any_empty),
        .empty_way (empty_way)
    );

    assign src = any_empty ? PICK_FILL : PICK_TREE;

    always_comb begin
        unique case (src)
            PICK_FILL: victim_way = empty_way;
            PICK_TREE: victim_way = tree_way;
            default:   victim_way = tree_way;
        endcase
    end

    AST_FILL_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec != 8'hFF) |-> !valid_vec[victim_way]); // R2

    AST_FILL_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec != 8'hFF) |-> ((valid_vec & ((8'd1 << victim_way) - 8'd1))
                                   == ((8'd1 << victim_way) - 8'd1))); // R2

    AST_AVOID_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (set_idx != $past(set_idx)) || (tree_way != $past(touch_way))); // R8

    AST_FULL_USES_TREE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec == 8'hFF) |-> (victim_way == tree_way)); // R3

endmodule

// File: tb/tplru8_sel_test.sv
`timescale 1ns/1ps
module tplru8_sel_test;

    localparam int SETS = 128;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] set_idx;
    logic [7:0] valid_vec;
    logic       touch_en;
    logic [2:0] touch_way;
    logic [2:0] victim_way;

    int checks = 0;
    int errors = 0;

    bit [6:0] mtree [SETS];

    always #2.5 clk = ~clk;

    tplru8_sel #(.SETS(SETS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (set_idx),
        .valid_vec  (valid_vec),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .victim_way (victim_way)
    );

    function automatic int model_victim(int s, bit [7:0] v);
        bit [6:0] t;
        for (int i = 0; i < 8; i++) begin
            if (!v[i]) return i;
        end
        t = mtree[s];
        if (t[0]) begin
            if (t[2]) return t[6] ? 7 : 6;
            return t[5] ? 5 : 4;
        end
        if (t[1]) return t[4] ? 3 : 2;
        return t[3] ? 1 : 0;
    endfunction

    task automatic model_touch(int s, int w);
        bit [6:0] t;
        t = mtree[s];
        case (w)
            0: begin t[0] = 1; t[1] = 1; t[3] = 1; end
            1: begin t[0] = 1; t[1] = 1; t[3] = 0; end
            2: begin t[0] = 1; t[4] = 1; t[1] = 0; end
            3: begin t[0] = 1; t[1] = 0; t[4] = 0; end
            4: begin t[2] = 1; t[5] = 1; t[0] = 0; end
            5: begin t[2] = 1; t[0] = 0; t[5] = 0; end
            6: begin t[6] = 1; t[0] = 0; t[2] = 0; end
            default: begin t[0] = 0; t[2] = 0; t[6] = 0; end
        endcase
        mtree[s] = t;
    endtask

    task automatic check(int actual, int expected, string tag);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: victim actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // One clock: drive at falling edge, compare before rising edge, update model at it.
    task automatic step(int s, bit [7:0] v, bit en, int w, string tag);
        @(negedge clk);
        set_idx   = 7'(s);
        valid_vec = v;
        touch_en  = en;
        touch_way = 3'(w);
        #1;
        check(int'(victim_way), model_victim(s, v), tag);
        @(posedge clk);
        if (en) model_touch(s, w);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) mtree[s] = '0;
        rst_n = 1'b0; set_idx = '0; valid_vec = 8'hFF; touch_en = 1'b0; touch_way = '0;
        repeat (3) @(posedge clk);
        #1;
        check(int'(victim_way), 0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all sets start at the zero tree
        step(0, 8'hFF, 0, 0, "R1");
        step(77, 8'hFF, 0, 0, "R1");
        step(127, 8'hFF, 0, 0, "R1");

        // R2: lowest empty way
        step(3, 8'h00, 0, 0, "R2");
        step(3, 8'hFE, 0, 0, "R2");
        step(3, 8'h7F, 0, 0, "R2");
        step(3, 8'hEF, 0, 0, "R2");
        step(3, 8'h5B, 0, 0, "R2");

        // R4 and R8: each way's touch pattern seen through the walk
        for (int w = 0; w < 8; w++) begin
            step(10, 8'hFF, 1, w, "R4 touch");
            step(10, 8'hFF, 0, 0, "R4");
            checks++;
            if (int'(victim_way) == w) begin
                errors++;
                $display("FAIL R8: victim actual=%0d expected=not %0d", victim_way, w);
            end
        end

        // R3: walk over several built-up trees
        step(20, 8'hFF, 1, 4, "R3");
        step(20, 8'hFF, 1, 0, "R3");
        step(20, 8'hFF, 1, 2, "R3");
        step(20, 8'hFF, 1, 6, "R3");
        step(20, 8'hFF, 0, 0, "R3");

        // R5: same-cycle read sees old tree, next cycle the new
        step(40, 8'hFF, 1, 0, "R5 same cycle");
        step(40, 8'hFF, 0, 0, "R5 next cycle");

        // R6: neighbour sets untouched
        step(30, 8'hFF, 1, 1, "R6");
        step(31, 8'hFF, 0, 0, "R6");
        step(29, 8'hFF, 0, 0, "R6");
        step(30, 8'hFF, 0, 0, "R6");

        // R7: no strobe, varied inputs, state held
        for (int k = 0; k < 16; k++) step(k * 7, 8'(k * 37) | 8'h01, 0, k % 8, "R7");
        step(10, 8'hFF, 0, 0, "R7");
        step(20, 8'hFF, 0, 0, "R7");

        // R9: touch with empty ways present still updates tree
        step(50, 8'h0F, 1, 5, "R9 fill");
        step(50, 8'h3F, 1, 1, "R9 fill");
        step(50, 8'hFF, 0, 0, "R9");

        // Mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            int r;
            int s;
            bit [7:0] v;
            r = int'($urandom);
            s = r & 7;
            v = (r[10:8] == 3'd0) ? 8'(r >> 16) : 8'hFF;
            step(s, v, r[4], (r >> 5) & 7, v == 8'hFF ? "R3 rand" : "R2 rand");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule